// File: doc/BRIEF.md
# Thread-Context Migration Flit Codec

This block converts a departing thread context into a packet of 64-bit flits for the input buffer of a mesh router. It also rebuilds a context from a packet that arrives at the core. A departing context consists of a program counter, a thread identifier, a destination core, and a chosen number of entries from the top of the main and auxiliary stacks. Sending only part of the stacks keeps migration traffic small. A context that leaves a guest slot has no memory behind its stacks, so it always carries every occupied entry.

On the send side, a one-cycle trigger presents the head flit combinationally in that same cycle. When the router is not back-pressuring, the head is taken on that edge. Body flits follow at one per accepted cycle, with two 32-bit stack words in each. The stack words are fetched through a dual combinational read port.

On the receive side, the head flit is decoded and its program counter is presented one cycle later, so fetch can start while the body is still arriving. Each body flit then produces up to two writes into the stack storage of the arriving context. A done pulse accompanies the final writes.

Top module: `ctx_mig_codec`

## Requirements
- R1: Head flit layout: PC in bits [31:0], thread ID in [39:32], main count in [44:40], auxiliary count in [48:45], body length in [52:49], destination in [59:53], and bits [63:60] zero.
- R2: When the sender is idle, `tx_go` makes `fo_valid` high with the head flit in the same cycle.
- R3: Body length equals ceil(main/2)+ceil(aux/2). Main words go first, then auxiliary words. Stack position 0 is the top of its stack. Each flit holds the even position in [31:0] and the next position in [63:32]. The upper half is zero when a stack's count is odd and that position is unused.
- R4: For a native departure (`tx_guest`=0), the main count is `tx_main_req` clamped to the range 2..16, and the auxiliary count is `tx_aux_req` clamped to 0..8. The smallest packet is therefore one head flit plus one body flit.
- R5: For a guest departure (`tx_guest`=1), the counts come from `tx_main_occ` and `tx_aux_occ`, with the same clamps.
- R6: While `fo_valid` is high and `fo_ready` is low, `fo_data` and `fo_last` hold their values into the next cycle.
- R7: `fo_last` is high on the final body flit only. After that flit is accepted the sender is idle.
- R8: `tx_go` while `tx_busy` is high is ignored and produces no flit.
- R9: One cycle after a head flit is accepted, `rx_head_v` pulses with the decoded PC, thread ID, destination and counts. No stack write occurs in that cycle.
- R10: Each body flit accepted on the input causes one cycle later a write of its lower word (`wr_en0`) and, unless the upper word is padding, its upper word (`wr_en1`). The write goes to the auxiliary stack when `wr_aux` is 1. The words land at the positions defined in R3. `rx_done` pulses together with the writes of the last body flit.
- R11: During and after reset, `fo_valid`, `tx_busy`, `rx_head_v`, `wr_en0` and `rx_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_go | input | 1 | Departure trigger pulse |
| tx_guest | input | 1 | Departing thread occupies the guest slot |
| tx_dest | input | 7 | Destination core |
| tx_tid | input | 8 | Thread identifier |
| tx_pc | input | 32 | Program counter of departing thread |
| tx_main_req | input | 5 | Requested main-stack entries (native) |
| tx_aux_req | input | 4 | Requested auxiliary entries (native) |
| tx_main_occ | input | 5 | Occupied main-stack entries (guest) |
| tx_aux_occ | input | 4 | Occupied auxiliary entries (guest) |
| tx_busy | output | 1 | Packet in progress |
| rd_aux | output | 1 | Read selects auxiliary stack |
| rd_pos0 | output | 4 | Read position, lower word |
| rd_pos1 | output | 4 | Read position, upper word |
| rd_word0 | input | 32 | Stack word at rd_pos0 |
| rd_word1 | input | 32 | Stack word at rd_pos1 |
| fo_valid | output | 1 | Outgoing flit valid |
| fo_ready | input | 1 | Router buffer can accept |
| fo_data | output | 64 | Outgoing flit |
| fo_last | output | 1 | Final flit of packet |
| fi_valid | input | 1 | Incoming flit valid |
| fi_data | input | 64 | Incoming flit |
| rx_head_v | output | 1 | Decoded head presented |
| rx_dest | output | 7 | Received destination |
| rx_tid | output | 8 | Received thread ID |
| rx_pc | output | 32 | Received program counter |
| rx_main_cnt | output | 5 | Received main count |
| rx_aux_cnt | output | 4 | Received auxiliary count |
| wr_en0 | output | 1 | Write enable, lower word |
| wr_en1 | output | 1 | Write enable, upper word |
| wr_aux | output | 1 | Writes target auxiliary stack |
| wr_pos0 | output | 4 | Write position, lower word |
| wr_pos1 | output | 4 | Write position, upper word |
| wr_word0 | output | 32 | Write data, lower word |
| wr_word1 | output | 32 | Write data, upper word |
| rx_done | output | 1 | Last stack writes of packet |

## Verification
The checker enforces on every cycle that a trigger yields a same-cycle head, that stalled flits stay stable, and that head count fields respect the clamps and the length formula. It also enforces that the sender goes idle after its last flit, and that received writes never coincide with the head pulse and never use the upper lane alone. Only the bench scenarios can show the content of the packets: word order, padding, the native-versus-guest choice of counts, the ignored mid-packet trigger, and that a looped-back packet rebuilds exactly the stack slice that was sent.

// File: rtl/ctx_mig_pkg.sv
package ctx_mig_pkg;
  localparam int FLIT_W = 64;
  localparam int WORD_W = 32;
  localparam int TID_W  = 8;
  localparam int DEST_W = 7;
  localparam int MAIN_D = 16;
  localparam int AUX_D  = 8;
  localparam int MIN_MAIN = 2;

  localparam int MCNT_W   = $clog2(MAIN_D + 1);
  localparam int ACNT_W   = $clog2(AUX_D + 1);
  localparam int POS_W    = $clog2(MAIN_D);
  localparam int MAX_BODY = (MAIN_D + 1) / 2 + (AUX_D + 1) / 2;
  localparam int BLEN_W   = $clog2(MAX_BODY + 1);
  localparam int RSV_W    = FLIT_W - (DEST_W + BLEN_W + ACNT_W + MCNT_W + TID_W + WORD_W);

  // Head flit, most significant field first.
  typedef struct packed {
    logic [RSV_W-1:0]  rsv;
    logic [DEST_W-1:0] dest;
    logic [BLEN_W-1:0] blen;
    logic [ACNT_W-1:0] acnt;
    logic [MCNT_W-1:0] mcnt;
    logic [TID_W-1:0]  tid;
    logic [WORD_W-1:0] pc;
  } head_t;

  // Stack slice carried by one body flit.
  typedef struct packed {
    logic             aux;
    logic [POS_W-1:0] p0;
    logic [POS_W-1:0] p1;
    logic             v1;
  } slot_t;

  typedef enum logic [1:0] {T_IDLE, T_HEAD, T_BODY} tx_st_t;
  typedef enum logic       {R_IDLE, R_BODY} rx_st_t;

  function automatic logic [MCNT_W-1:0] clamp_main(input logic [MCNT_W-1:0] x);
    if (int'(x) < MIN_MAIN) return MCNT_W'(MIN_MAIN);
    if (int'(x) > MAIN_D)   return MCNT_W'(MAIN_D);
    return x;
  endfunction

  function automatic logic [ACNT_W-1:0] clamp_aux(input logic [ACNT_W-1:0] x);
    if (int'(x) > AUX_D) return ACNT_W'(AUX_D);
    return x;
  endfunction

  function automatic logic [BLEN_W-1:0] body_len(input logic [MCNT_W-1:0] m,
                                                 input logic [ACNT_W-1:0] a);
    return BLEN_W'((int'(m) + 1) / 2 + (int'(a) + 1) / 2);
  endfunction

  // Maps body flit index k to stack, positions and upper-word validity.
  function automatic slot_t locate(input logic [BLEN_W-1:0] k,
                                   input logic [MCNT_W-1:0] m,
                                   input logic [ACNT_W-1:0] a);
    slot_t s;
    int mfl;
    int j;
    int lim;
    mfl = (int'(m) + 1) / 2;
    if (int'(k) < mfl) begin
      s.aux = 1'b0;
      j     = int'(k);
      lim   = int'(m);
    end else begin
      s.aux = 1'b1;
      j     = int'(k) - mfl;
      lim   = int'(a);
    end
    s.p0 = POS_W'(2 * j);
    s.p1 = POS_W'(2 * j + 1);
    s.v1 = (2 * j + 1) < lim;
    return s;
  endfunction
endpackage

// File: rtl/ctx_mig_tx.sv
module ctx_mig_tx
  import ctx_mig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_go,
  input  logic              tx_guest,
  input  logic [DEST_W-1:0] tx_dest,
  input  logic [TID_W-1:0]  tx_tid,
  input  logic [WORD_W-1:0] tx_pc,
  input  logic [MCNT_W-1:0] tx_main_req,
  input  logic [ACNT_W-1:0] tx_aux_req,
  input  logic [MCNT_W-1:0] tx_main_occ,
  input  logic [ACNT_W-1:0] tx_aux_occ,
  output logic              tx_busy,
  output logic              rd_aux,
  output logic [POS_W-1:0]  rd_pos0,
  output logic [POS_W-1:0]  rd_pos1,
  input  logic [WORD_W-1:0] rd_word0,
  input  logic [WORD_W-1:0] rd_word1,
  output logic              fo_valid,
  input  logic              fo_ready,
  output logic [FLIT_W-1:0] fo_data,
  output logic              fo_last
);
  tx_st_t            state_q, state_d;
  head_t             hd_q, hd_d, live;
  logic              hd_en;
  logic [BLEN_W-1:0] k_q, k_d;
  slot_t             slot;
  logic [MCNT_W-1:0] em;
  logic [ACNT_W-1:0] ea;
  logic              at_end;

  // Guest departures carry every occupied entry; native ones carry the request.
  always_comb begin
    em        = clamp_main(tx_guest ? tx_main_occ : tx_main_req);
    ea        = clamp_aux(tx_guest ? tx_aux_occ : tx_aux_req);
    live.rsv  = '0;
    live.dest = tx_dest;
    live.blen = body_len(em, ea);
    live.acnt = ea;
    live.mcnt = em;
    live.tid  = tx_tid;
    live.pc   = tx_pc;
  end

  assign slot    = locate(k_q, hd_q.mcnt, hd_q.acnt);
  assign rd_aux  = slot.aux;
  assign rd_pos0 = slot.p0;
  assign rd_pos1 = slot.p1;
  assign at_end  = (k_q == hd_q.blen - 1'b1);
  assign tx_busy = (state_q != T_IDLE);

  always_comb begin
    state_d  = state_q;
    hd_d     = hd_q;
    hd_en    = 1'b0;
    k_d      = k_q;
    fo_valid = 1'b0;
    fo_data  = hd_q;
    fo_last  = 1'b0;
    unique case (state_q)
      T_IDLE: begin
        fo_valid = tx_go;
        fo_data  = live;
        if (tx_go) begin
          hd_d    = live;
          hd_en   = 1'b1;
          k_d     = '0;
          state_d = fo_ready ? T_BODY : T_HEAD;
        end
      end
      T_HEAD: begin
        fo_valid = 1'b1;
        fo_data  = hd_q;
        if (fo_ready) state_d = T_BODY;
      end
      T_BODY: begin
        fo_valid = 1'b1;
        fo_data  = {(slot.v1 ? rd_word1 : {WORD_W{1'b0}}), rd_word0};
        fo_last  = at_end;
        if (fo_ready) begin
          if (at_end) state_d = T_IDLE;
          else        k_d     = k_q + 1'b1;
        end
      end
      default: state_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= T_IDLE;
      k_q     <= '0;
    end else begin
      state_q <= state_d;
      k_q     <= k_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hd_q <= '0;
    else if (hd_en) hd_q <= hd_d;
  end
endmodule

// File: rtl/ctx_mig_rx.sv
module ctx_mig_rx
  import ctx_mig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fi_valid,
  input  logic [FLIT_W-1:0] fi_data,
  output logic              rx_head_v,
  output logic [DEST_W-1:0] rx_dest,
  output logic [TID_W-1:0]  rx_tid,
  output logic [WORD_W-1:0] rx_pc,
  output logic [MCNT_W-1:0] rx_main_cnt,
  output logic [ACNT_W-1:0] rx_aux_cnt,
  output logic              wr_en0,
  output logic              wr_en1,
  output logic              wr_aux,
  output logic [POS_W-1:0]  wr_pos0,
  output logic [POS_W-1:0]  wr_pos1,
  output logic [WORD_W-1:0] wr_word0,
  output logic [WORD_W-1:0] wr_word1,
  output logic              rx_done
);
  rx_st_t            state_q, state_d;
  head_t             hd_q, hin;
  logic              hd_en;
  logic [BLEN_W-1:0] k_q, k_d;
  slot_t             slot;
  logic              body_acc, at_end;
  logic              head_v_q, en0_q, en1_q, done_q;
  logic              aux_q;
  logic [POS_W-1:0]  pos0_q, pos1_q;
  logic [WORD_W-1:0] w0_q, w1_q;

  assign hin      = head_t'(fi_data);
  assign slot     = locate(k_q, hd_q.mcnt, hd_q.acnt);
  assign at_end   = (k_q == hd_q.blen - 1'b1);
  assign body_acc = fi_valid && (state_q == R_BODY);

  always_comb begin
    state_d = state_q;
    hd_en   = 1'b0;
    k_d     = k_q;
    unique case (state_q)
      R_IDLE: if (fi_valid) begin
        hd_en = 1'b1;
        k_d   = '0;
        // A head with no body or nonzero reserved bits starts no body phase.
        if (hin.blen != '0 && hin.rsv == '0) state_d = R_BODY;
      end
      R_BODY: if (fi_valid) begin
        k_d = k_q + 1'b1;
        if (at_end) state_d = R_IDLE;
      end
      default: state_d = R_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= R_IDLE;
      k_q      <= '0;
      head_v_q <= 1'b0;
      en0_q    <= 1'b0;
      en1_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      k_q      <= k_d;
      head_v_q <= hd_en;
      en0_q    <= body_acc;
      en1_q    <= body_acc && slot.v1;
      done_q   <= body_acc && at_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hd_q <= '0;
    else if (hd_en) hd_q <= hin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q  <= 1'b0;
      pos0_q <= '0;
      pos1_q <= '0;
      w0_q   <= '0;
      w1_q   <= '0;
    end else if (body_acc) begin
      aux_q  <= slot.aux;
      pos0_q <= slot.p0;
      pos1_q <= slot.p1;
      w0_q   <= fi_data[WORD_W-1:0];
      w1_q   <= fi_data[FLIT_W-1:WORD_W];
    end
  end

  assign rx_head_v   = head_v_q;
  assign rx_dest     = hd_q.dest;
  assign rx_tid      = hd_q.tid;
  assign rx_pc       = hd_q.pc;
  assign rx_main_cnt = hd_q.mcnt;
  assign rx_aux_cnt  = hd_q.acnt;
  assign wr_en0      = en0_q;
  assign wr_en1      = en1_q;
  assign wr_aux      = aux_q;
  assign wr_pos0     = pos0_q;
  assign wr_pos1     = pos1_q;
  assign wr_word0    = w0_q;
  assign wr_word1    = w1_q;
  assign rx_done     = done_q;
endmodule

// File: rtl/ctx_mig_codec.sv
module ctx_mig_codec
  import ctx_mig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_go,
  input  logic              tx_guest,
  input  logic [DEST_W-1:0] tx_dest,
  input  logic [TID_W-1:0]  tx_tid,
  input  logic [WORD_W-1:0] tx_pc,
  input  logic [MCNT_W-1:0] tx_main_req,
  input  logic [ACNT_W-1:0] tx_aux_req,
  input  logic [MCNT_W-1:0] tx_main_occ,
  input  logic [ACNT_W-1:0] tx_aux_occ,
  output logic              tx_busy,
  output logic              rd_aux,
  output logic [POS_W-1:0]  rd_pos0,
  output logic [POS_W-1:0]  rd_pos1,
  input  logic [WORD_W-1:0] rd_word0,
  input  logic [WORD_W-1:0] rd_word1,
  output logic              fo_valid,
  input  logic              fo_ready,
  output logic [FLIT_W-1:0] fo_data,
  output logic              fo_last,
  input  logic              fi_valid,
  input  logic [FLIT_W-1:0] fi_data,
  output logic              rx_head_v,
  output logic [DEST_W-1:0] rx_dest,
  output logic [TID_W-1:0]  rx_tid,
  output logic [WORD_W-1:0] rx_pc,
  output logic [MCNT_W-1:0] rx_main_cnt,
  output logic [ACNT_W-1:0] rx_aux_cnt,
  output logic              wr_en0,
  output logic              wr_en1,
  output logic              wr_aux,
  output logic [POS_W-1:0]  wr_pos0,
  output logic [POS_W-1:0]  wr_pos1,
  output logic [WORD_W-1:0] wr_word0,
  output logic [WORD_W-1:0] wr_word1,
  output logic              rx_done
);
  ctx_mig_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .tx_guest(tx_guest),
    .tx_dest(tx_dest), .tx_tid(tx_tid), .tx_pc(tx_pc),
    .tx_main_req(tx_main_req), .tx_aux_req(tx_aux_req),
    .tx_main_occ(tx_main_occ), .tx_aux_occ(tx_aux_occ), .tx_busy(tx_busy),
    .rd_aux(rd_aux), .rd_pos0(rd_pos0), .rd_pos1(rd_pos1),
    .rd_word0(rd_word0), .rd_word1(rd_word1),
    .fo_valid(fo_valid), .fo_ready(fo_ready), .fo_data(fo_data), .fo_last(fo_last)
  );

  ctx_mig_rx u_rx (
    .clk(clk), .rst_n(rst_n), .fi_valid(fi_valid), .fi_data(fi_data),
    .rx_head_v(rx_head_v), .rx_dest(rx_dest), .rx_tid(rx_tid), .rx_pc(rx_pc),
    .rx_main_cnt(rx_main_cnt), .rx_aux_cnt(rx_aux_cnt),
    .wr_en0(wr_en0), .wr_en1(wr_en1), .wr_aux(wr_aux),
    .wr_pos0(wr_pos0), .wr_pos1(wr_pos1), .wr_word0(wr_word0), .wr_word1(wr_word1),
    .rx_done(rx_done)
  );
endmodule

// File: rtl/ctx_mig_codec_chk.sv
module ctx_mig_codec_chk
  import ctx_mig_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tx_go,
  input logic              tx_busy,
  input logic              fo_valid,
  input logic              fo_ready,
  input logic [FLIT_W-1:0] fo_data,
  input logic              fo_last,
  input logic              rx_head_v,
  input logic              wr_en0,
  input logic              wr_en1,
  input logic              rx_done
);
  head_t h;
  assign h = head_t'(fo_data);

  p_go_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go && !tx_busy |-> fo_valid);

  p_blen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fo_valid && !tx_busy |->
      int'(h.blen) == (int'(h.mcnt) + 1) / 2 + (int'(h.acnt) + 1) / 2);

  p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fo_valid && !tx_busy |->
      int'(h.mcnt) >= MIN_MAIN && int'(h.mcnt) <= MAIN_D && int'(h.acnt) <= AUX_D);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fo_valid && !fo_ready |=> fo_valid && $stable(fo_data) && $stable(fo_last));

  p_idle_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fo_valid && fo_ready && fo_last |=> !tx_busy);

  p_head_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_head_v |-> !wr_en0);

  p_upper_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en1 |-> wr_en0);

  p_done_with_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> wr_en0);
endmodule

bind ctx_mig_codec ctx_mig_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .tx_busy(tx_busy),
  .fo_valid(fo_valid), .fo_ready(fo_ready), .fo_data(fo_data), .fo_last(fo_last),
  .rx_head_v(rx_head_v), .wr_en0(wr_en0), .wr_en1(wr_en1), .rx_done(rx_done)
);

// File: tb/ctx_mig_codec_bench.sv
`timescale 1ns/1ps
module ctx_mig_codec_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        tx_go, tx_guest, fo_ready, bp_en;
  logic [6:0]  tx_dest;
  logic [7:0]  tx_tid;
  logic [31:0] tx_pc;
  logic [4:0]  tx_main_req, tx_main_occ;
  logic [3:0]  tx_aux_req, tx_aux_occ;
  logic        tx_busy, rd_aux, fo_valid, fo_last, fi_valid;
  logic [3:0]  rd_pos0, rd_pos1, wr_pos0, wr_pos1;
  logic [31:0] rd_word0, rd_word1, wr_word0, wr_word1, rx_pc;
  logic [63:0] fo_data, fi_data;
  logic        rx_head_v, wr_en0, wr_en1, wr_aux, rx_done;
  logic [6:0]  rx_dest;
  logic [7:0]  rx_tid;
  logic [4:0]  rx_main_cnt;
  logic [3:0]  rx_aux_cnt;

  logic [31:0] mstk [16];
  logic [31:0] astk [8];
  logic [31:0] rm [16];
  logic [31:0] ra [8];
  logic [15:0] rmask;
  logic [7:0]  amask;
  logic [7:0]  cyc;
  logic [7:0]  bp_pat = 8'b1001_0110;

  assign rd_word0 = rd_aux ? astk[rd_pos0[2:0]] : mstk[rd_pos0];
  assign rd_word1 = rd_aux ? astk[rd_pos1[2:0]] : mstk[rd_pos1];
  assign fo_ready = !bp_en || bp_pat[cyc[2:0]];
  assign fi_valid = fo_valid && fo_ready;
  assign fi_data  = fo_data;

  ctx_mig_codec u_ctx_mig_codec (.*);

  int nchk = 0;
  int nbad = 0;
  logic [64:0] exp_q [$];
  logic got_hd, done_seen, wr_before_hd, stall_prev;
  logic [63:0] data_prev;
  logic last_prev;

  task automatic chk(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 8'd1;

  // Monitor: scoreboard of outgoing flits, hold check, and receive capture.
  always @(negedge clk) if (rst_n) begin
    logic [64:0] e;
    if (stall_prev)
      chk(fo_valid && fo_data == data_prev && fo_last == last_prev, "R6 stalled flit held",
          {fo_last, fo_data}, {last_prev, data_prev});
    stall_prev = fo_valid && !fo_ready;
    data_prev  = fo_data;
    last_prev  = fo_last;
    if (fo_valid && fo_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected flit", {fo_last, fo_data}, '0);
      else begin
        e = exp_q.pop_front();
        chk({fo_last, fo_data} == e, "R1/R3/R7 flit content", {fo_last, fo_data}, e);
      end
    end
    if (rx_head_v) got_hd = 1'b1;
    if (wr_en0) begin
      if (!got_hd) wr_before_hd = 1'b1;
      if (wr_aux) begin ra[wr_pos0[2:0]] = wr_word0; amask[wr_pos0[2:0]] = 1'b1; end
      else        begin rm[wr_pos0] = wr_word0;      rmask[wr_pos0] = 1'b1; end
    end
    if (wr_en1) begin
      if (wr_aux) begin ra[wr_pos1[2:0]] = wr_word1; amask[wr_pos1[2:0]] = 1'b1; end
      else        begin rm[wr_pos1] = wr_word1;      rmask[wr_pos1] = 1'b1; end
    end
    if (rx_done) done_seen = 1'b1;
  end

  task automatic fill(input int seed);
    for (int i = 0; i < 16; i++) mstk[i] = 32'hA000_0000 + seed * 256 + i;
    for (int i = 0; i < 8; i++)  astk[i] = 32'hB000_0000 + seed * 256 + i;
  endtask

  task automatic send(input logic [6:0] d, input logic [7:0] t, input logic [31:0] pc,
                      input int mreq, input int areq, input bit guest,
                      input int mocc, input int aocc, input bit poke);
    int em, ea, bl;
    logic [31:0] w [$];
    logic [63:0] hd;
    em = guest ? mocc : mreq;
    ea = guest ? aocc : areq;
    if (em < 2) em = 2;
    if (em > 16) em = 16;
    if (ea > 8) ea = 8;
    bl = (em + 1) / 2 + (ea + 1) / 2;
    @(posedge clk); #1;
    got_hd = 0; done_seen = 0; wr_before_hd = 0; rmask = '0; amask = '0;
    // R1: head layout.
    hd = {4'h0, d, 4'(bl), 4'(ea), 5'(em), t, pc};
    exp_q.push_back({1'b0, hd});
    // R3: main words then aux, top first, odd counts padded with zero.
    for (int i = 0; i < em; i++) w.push_back(mstk[i]);
    if (em % 2) w.push_back(32'h0);
    for (int i = 0; i < ea; i++) w.push_back(astk[i]);
    if (ea % 2) w.push_back(32'h0);
    for (int k = 0; k < bl; k++) exp_q.push_back({(k == bl - 1), w[2*k+1], w[2*k]});
    tx_dest = d; tx_tid = t; tx_pc = pc; tx_guest = guest;
    tx_main_req = 5'(mreq); tx_aux_req = 4'(areq);
    tx_main_occ = 5'(mocc); tx_aux_occ = 4'(aocc);
    tx_go = 1'b1;
    @(negedge clk);
    chk(fo_valid && !tx_busy, "R2 head in trigger cycle", {64'h0, fo_valid}, 65'h1);
    @(posedge clk); #1;
    tx_go = 1'b0;
    tx_pc = ~pc; tx_main_req = 5'd3; tx_main_occ = 5'd3;
    if (poke) begin
      repeat (3) @(posedge clk);
      #1;
      chk(tx_busy, "R8 busy mid packet", {64'h0, tx_busy}, 65'h1);
      tx_go = 1'b1; tx_pc = 32'hDEAD_0001;
      @(posedge clk); #1;
      tx_go = 1'b0;
    end
    while (!done_seen) @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R7/R8 all flits and no extra", 65'(exp_q.size()), 65'h0);
    chk(!tx_busy && !fo_valid, "R7 idle after last", {63'h0, tx_busy, fo_valid}, 65'h0);
    chk(got_hd && !wr_before_hd, "R9 head before writes", {63'h0, got_hd, wr_before_hd}, 65'h2);
    chk(rx_pc == pc && rx_tid == t && rx_dest == d, "R9 decoded head",
        {rx_dest, rx_tid, rx_pc}, {d, t, pc});
    chk(int'(rx_main_cnt) == em && int'(rx_aux_cnt) == ea, "R4/R5 counts",
        {rx_main_cnt, rx_aux_cnt}, {5'(em), 4'(ea)});
    for (int i = 0; i < 16; i++) begin
      chk(rmask[i] == (i < em), "R10 main write mask", {64'h0, rmask[i]}, {64'h0, (i < em)});
      if (i < em) chk(rm[i] == mstk[i], "R10 main word", {33'h0, rm[i]}, {33'h0, mstk[i]});
    end
    for (int i = 0; i < 8; i++) begin
      chk(amask[i] == (i < ea), "R10 aux write mask", {64'h0, amask[i]}, {64'h0, (i < ea)});
      if (i < ea) chk(ra[i] == astk[i], "R10 aux word", {33'h0, ra[i]}, {33'h0, astk[i]});
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nbad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_go = 1'b0; tx_guest = 1'b0; bp_en = 1'b0; cyc = '0;
    tx_dest = '0; tx_tid = '0; tx_pc = '0; tx_main_req = '0; tx_aux_req = '0;
    tx_main_occ = '0; tx_aux_occ = '0; stall_prev = 1'b0; data_prev = '0; last_prev = 1'b0;
    got_hd = 0; done_seen = 0; wr_before_hd = 0; rmask = '0; amask = '0;
    fill(0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!fo_valid && !tx_busy && !rx_head_v && !wr_en0 && !rx_done, "R11 reset state",
        {60'h0, fo_valid, tx_busy, rx_head_v, wr_en0, rx_done}, 65'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!fo_valid && !tx_busy && !wr_en0, "R11 after reset",
        {62'h0, fo_valid, tx_busy, wr_en0}, 65'h0);

    fill(1); send(7'd5,   8'h11, 32'h0000_1000, 8,  0, 0, 0, 0, 0);  // R4 default slice
    fill(2); send(7'd77,  8'h22, 32'h1234_5678, 5,  3, 0, 0, 0, 0);  // R3 odd padding
    fill(3); send(7'd1,   8'h33, 32'h0000_0040, 0,  0, 0, 0, 0, 0);  // R4 minimum packet
    fill(4); send(7'd109, 8'hFE, 32'hFFFF_FFFC, 31, 15, 0, 0, 0, 0); // R4 clamp to max
    fill(5); send(7'd64,  8'h44, 32'h0BAD_F00D, 4,  0, 1, 11, 7, 0); // R5 guest occupancy
    bp_en = 1'b1;
    fill(6); send(7'd9,   8'h55, 32'h0000_2220, 9,  5, 0, 0, 0, 0);  // R6 back-pressure
    fill(7); send(7'd3,   8'h66, 32'h0000_3330, 3,  1, 1, 14, 2, 0); // R5/R6 guest stalled
    bp_en = 1'b0;
    fill(8); send(7'd42,  8'h77, 32'h0000_4440, 16, 8, 0, 0, 0, 1);  // R8 ignored trigger

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule